// File: doc/BRIEF.md
# Reload-Tracking Clock Calibrator

This block measures the frequency of its own clock against a slow, trusted reference pulse train, for example 50 Hz. It does not count clock cycles over a gated window. It steers a reload value instead. An internal timer runs on the system clock and emits one tick every `reload_val` cycles. A tick counter totals those ticks between two rising edges of the reference. At each reference edge the total is compared with `exp_ticks`, and the reload value moves by one toward agreement. A fast clock gives too many ticks, so the reload value goes up. A slow clock gives too few, so it goes down.

Once a run of `LOCK_RUN` consecutive intervals passes with no adjustment, the block reports lock and freezes the reload value. With `exp_ticks` set to the reference period in milliseconds (20 for a 50 Hz reference), the frozen reload value is the clock frequency in kHz. If the search tries to step below 1 or above the largest value the register can hold, the block raises a range flag and stops.

A pulse on `start` begins a search from any state. The controller is a five-state machine:

- **IDLE** is left only through `start` (transition *begin*).
- **ARM** waits for the first reference edge (transition *first_edge*, to TRACK).
- **TRACK** judges each interval. It takes one of three transitions: *step* (adjust and stay), *match* (count a passing interval and stay), or *settle* (the last needed match, to LOCKED). A clamp takes it to FAULT (transition *clamp*).
- **LOCKED** and **FAULT** hold until `start`. The transition *restart* goes from any state to ARM.

Top module: `clk_cal_tracker`

## Requirements
- R1: After reset the block is in IDLE with `reload_val` equal to `RELOAD_INIT` (default 1024), and `locked` and `range_err` both low. Reference edges have no effect until `start` is pulsed.
- R2: The reference passes through `SYNC_STAGES` (default 2) flops, and an interval boundary is a rising edge of the synchronised reference. The first boundary after `start` only opens an interval and never adjusts `reload_val`.
- R3: While tracking, the timer emits one tick every `reload_val` clock cycles, counting from the boundary at which it was loaded. The tick count is sampled at each boundary and then cleared to zero. A timer expiry that falls in the boundary cycle itself is not counted. The count saturates at its all-ones value.
- R4: If the sampled count is greater than `exp_ticks`, `reload_val` increases by exactly one.
- R5: If the sampled count is less than `exp_ticks`, `reload_val` decreases by exactly one.
- R6: If the sampled count equals `exp_ticks`, `reload_val` is unchanged and the consecutive-match run grows by one. Any adjustment resets the run to zero.
- R7: When the run reaches `LOCK_RUN` (default 50), `locked` goes high one cycle after that boundary. From then on `reload_val` is held and further reference edges are ignored.
- R8: If a decrease is needed while `reload_val` is 1, the value stays at 1, `range_err` goes high and the search stops.
- R9: If an increase is needed while `reload_val` is at its maximum (all ones of `RELOAD_W` bits), the value stays there, `range_err` goes high and the search stops.
- R10: `start` restarts the search from any state. In the following cycle `reload_val` equals `RELOAD_INIT` and both flags are low. A reference boundary in the same cycle as `start` is consumed, and the next boundary opens the first interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock whose frequency is being found |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference pulse train |
| start | input | 1 | One-cycle pulse that begins a new search |
| exp_ticks | input | TICK_W | Ticks expected per reference interval |
| reload_val | output | RELOAD_W | Current reload value (kHz once locked) |
| locked | output | 1 | Search converged |
| range_err | output | 1 | Search stopped at a range limit |

## Verification
Two events can fall in the same cycle, and both are provoked on purpose. The first is a timer expiry landing in the boundary cycle. Reference periods are chosen so that some intervals end exactly on a tick, and the bench checks that the tick is dropped rather than carried into the next interval. The second is a `start` pulse arriving in the same cycle that a synchronised reference edge is acted on. The bench watches its own model of the synchroniser, raises `start` exactly then, and checks two things: the restart wins, and no adjustment happens until a later boundary. A behavioural model updated on every clock judges `reload_val`, `locked` and `range_err` in all cycles.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_TRACK  = 3'd2,
        ST_LOCKED = 3'd3,
        ST_FAULT  = 3'd4
    } cal_state_t;

    typedef enum logic [1:0] {
        VERDICT_EQ   = 2'd0,
        VERDICT_LOW  = 2'd1,
        VERDICT_HIGH = 2'd2
    } verdict_t;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   hist_q;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= ref_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[SYNC_STAGES-1];
    end

    assign rise_pulse = chain_q[SYNC_STAGES-1] & ~hist_q;

    // R2
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int RELOAD_W = 16,
    parameter int TICK_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                load,
    input  logic [RELOAD_W-1:0] load_val,
    input  logic [RELOAD_W-1:0] cur_val,
    output logic [TICK_W-1:0]   tick_cnt
);
    logic [RELOAD_W-1:0] down_q;
    logic                expire;

    assign expire = (down_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            down_q   <= '0;
            tick_cnt <= '0;
        end else if (load) begin
            down_q   <= load_val - 1'b1;
            tick_cnt <= '0;
        end else if (run) begin
            if (expire) begin
                down_q <= cur_val - 1'b1;
                if (tick_cnt != '1) tick_cnt <= tick_cnt + 1'b1;
            end else begin
                down_q <= down_q - 1'b1;
            end
        end
    end

    // R3
    clear_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (tick_cnt == '0));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$stable(tick_cnt)) |-> (tick_cnt == $past(tick_cnt) + 1'b1));

endmodule

// File: rtl/interval_judge.sv
module interval_judge #(
    parameter int TICK_W = 8
) (
    input  logic [TICK_W-1:0] seen,
    input  logic [TICK_W-1:0] wanted,
    output cal_pkg::verdict_t verdict
);
    import cal_pkg::*;

    always_comb begin
        if (seen > wanted)      verdict = VERDICT_HIGH;
        else if (seen < wanted) verdict = VERDICT_LOW;
        else                    verdict = VERDICT_EQ;
    end

endmodule

// File: rtl/clk_cal_tracker.sv
module clk_cal_tracker #(
    parameter int RELOAD_W    = 16,
    parameter int RELOAD_INIT = 1024,
    parameter int TICK_W      = 8,
    parameter int LOCK_RUN    = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_in,
    input  logic                start,
    input  logic [TICK_W-1:0]   exp_ticks,
    output logic [RELOAD_W-1:0] reload_val,
    output logic                locked,
    output logic                range_err
);
    import cal_pkg::*;

    localparam int                  MATCH_W   = $clog2(LOCK_RUN + 1);
    localparam logic [RELOAD_W-1:0] INIT_V    = RELOAD_W'(RELOAD_INIT);
    localparam logic [RELOAD_W-1:0] MAX_V     = '1;
    localparam logic [RELOAD_W-1:0] MIN_V     = RELOAD_W'(1);
    localparam logic [MATCH_W-1:0]  LAST_HIT  = MATCH_W'(LOCK_RUN - 1);

    cal_state_t          state_q, state_d;
    logic [RELOAD_W-1:0] reload_q, reload_d;
    logic [MATCH_W-1:0]  match_q, match_d;
    logic                boundary;
    logic                tmr_load;
    logic                tmr_run;
    logic [TICK_W-1:0]   tick_cnt;
    verdict_t            verdict;

    ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_async  (ref_in),
        .rise_pulse (boundary)
    );

    tick_timer #(.RELOAD_W(RELOAD_W), .TICK_W(TICK_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .load     (tmr_load),
        .load_val (reload_d),
        .cur_val  (reload_q),
        .tick_cnt (tick_cnt)
    );

    interval_judge #(.TICK_W(TICK_W)) i_judge (
        .seen    (tick_cnt),
        .wanted  (exp_ticks),
        .verdict (verdict)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // search registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= INIT_V;
            match_q  <= '0;
        end else begin
            reload_q <= reload_d;
            match_q  <= match_d;
        end
    end

    // next-state and search update
    always_comb begin
        state_d  = state_q;
        reload_d = reload_q;
        match_d  = match_q;
        tmr_load = 1'b0;
        if (start) begin
            state_d  = ST_ARM;
            reload_d = INIT_V;
            match_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ARM: begin
                    if (boundary) begin
                        tmr_load = 1'b1;
                        state_d  = ST_TRACK;
                    end
                end
                ST_TRACK: begin
                    if (boundary) begin
                        tmr_load = 1'b1;
                        unique case (verdict)
                            VERDICT_HIGH: begin
                                if (reload_q == MAX_V) begin
                                    state_d = ST_FAULT;
                                end else begin
                                    reload_d = reload_q + 1'b1;
                                    match_d  = '0;
                                end
                            end
                            VERDICT_LOW: begin
                                if (reload_q == MIN_V) begin
                                    state_d = ST_FAULT;
                                end else begin
                                    reload_d = reload_q - 1'b1;
                                    match_d  = '0;
                                end
                            end
                            VERDICT_EQ: begin
                                match_d = match_q + 1'b1;
                                if (match_q == LAST_HIT) state_d = ST_LOCKED;
                            end
                            default: begin
                            end
                        endcase
                    end
                end
                ST_LOCKED: begin
                end
                ST_FAULT: begin
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign tmr_run = (state_q == ST_TRACK);

    // outputs
    always_comb begin
        reload_val = reload_q;
        locked     = (state_q == ST_LOCKED);
        range_err  = (state_q == ST_FAULT);
    end

    // R4 R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && !$stable(reload_val)) |->
        ((reload_val == $past(reload_val) + 1'b1) || (reload_val == $past(reload_val) - 1'b1)));

    // R8
    reload_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_val != '0);

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) && locked) |-> $stable(reload_val));

    // R10
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (reload_val == INIT_V && !locked && !range_err));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && range_err));

    // R6
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && !$stable(reload_val)) |-> (match_q == '0));

endmodule

// File: tb/test_clk_cal_tracker.sv
module test_clk_cal_tracker;
    localparam int RW    = 7;
    localparam int INIT  = 14;
    localparam int TW    = 8;
    localparam int RUN   = 4;
    localparam int RMAX  = (1 << RW) - 1;
    localparam int CMAX  = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] exp_ticks = 8'd20;
    logic [RW-1:0] reload_val;
    logic          locked;
    logic          range_err;

    int checks = 0;
    int fails  = 0;
    int ref_per = 201;
    int ref_ph  = 0;

    always #5 clk = ~clk;

    clk_cal_tracker #(.RELOAD_W(RW), .RELOAD_INIT(INIT), .TICK_W(TW),
                      .LOCK_RUN(RUN), .SYNC_STAGES(2)) i_clk_cal_tracker (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .start(start),
        .exp_ticks(exp_ticks), .reload_val(reload_val),
        .locked(locked), .range_err(range_err)
    );

    // reference generator: rising edge every ref_per cycles
    always @(negedge clk) begin
        if (ref_ph >= ref_per - 1) ref_ph = 0;
        else                       ref_ph = ref_ph + 1;
        ref_in = (ref_ph < ref_per / 2);
    end

    // behavioural model: 0 idle, 1 arm, 2 track, 3 locked, 4 fault
    int ms1, ms2, ms3, mst, mrel, mmatch, mc, mcnt;
    bit medge;
    always @(posedge clk) begin
        if (!rst_n) begin
            ms1 = 0; ms2 = 0; ms3 = 0; mst = 0; mrel = INIT;
            mmatch = 0; mc = 0; mcnt = 0;
        end else begin
            medge = (ms2 == 1) && (ms3 == 0);
            ms3 = ms2; ms2 = ms1; ms1 = int'(ref_in);
            if (start) begin
                mst = 1; mrel = INIT; mmatch = 0;
            end else if (mst == 1) begin
                if (medge) begin mc = mrel - 1; mcnt = 0; mst = 2; end
            end else if (mst == 2) begin
                if (medge) begin
                    if (mcnt > int'(exp_ticks)) begin
                        if (mrel == RMAX) mst = 4;
                        else begin mrel = mrel + 1; mmatch = 0; end
                    end else if (mcnt < int'(exp_ticks)) begin
                        if (mrel == 1) mst = 4;
                        else begin mrel = mrel - 1; mmatch = 0; end
                    end else begin
                        mmatch = mmatch + 1;
                        if (mmatch == RUN) mst = 3;
                    end
                    mc = mrel - 1; mcnt = 0;
                end else if (mc == 0) begin
                    mc = mrel - 1;
                    if (mcnt < CMAX) mcnt = mcnt + 1;
                end else begin
                    mc = mc - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(reload_val) == mrel, "R4 R5 R6 reload_val vs model", int'(reload_val), mrel);
            chk(locked == (mst == 3), "R7 locked vs model", int'(locked), int'(mst == 3));
            chk(range_err == (mst == 4), "R8 R9 range_err vs model", int'(range_err), int'(mst == 4));
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_flag(input bit want_lock, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (want_lock ? locked : range_err) break;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, then ignore reference without start
        chk(reload_val == RW'(INIT) && !locked && !range_err, "R1 reset state", int'(reload_val), INIT);
        repeat (600) @(negedge clk);
        chk(reload_val == RW'(INIT) && !locked, "R1 idle ignores reference", int'(reload_val), INIT);

        // R2 first boundary only arms; R5 and R3 converge down to 10
        pulse_start();
        for (int i = 0; i < 1000; i++) begin @(negedge clk); if (mst == 2) break; end
        @(negedge clk);
        chk(reload_val == RW'(INIT), "R2 first boundary does not adjust", int'(reload_val), INIT);
        wait_flag(1'b1, 5000);
        chk(locked == 1'b1, "R7 lock reached", int'(locked), 1);
        chk(reload_val == 7'd10, "R5 R3 decreased to period match", int'(reload_val), 10);
        repeat (1000) @(negedge clk);
        chk(locked && reload_val == 7'd10, "R7 held after lock", int'(reload_val), 10);

        // R4 increase toward 19 with fewer expected ticks
        exp_ticks = 8'd10;
        pulse_start();
        wait_flag(1'b1, 5000);
        chk(locked && reload_val == 7'd19, "R4 increased to period match", int'(reload_val), 19);

        // R8 low clamp
        exp_ticks = 8'd255;
        pulse_start();
        wait_flag(1'b0, 6000);
        chk(range_err && reload_val == 7'd1, "R8 low clamp", int'(reload_val), 1);
        repeat (800) @(negedge clk);
        chk(range_err && reload_val == 7'd1, "R8 search stopped", int'(reload_val), 1);

        // R10 restart from fault coinciding with a reference boundary
        exp_ticks = 8'd20;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (ms2 == 1 && ms3 == 0) break;
        end
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(reload_val == RW'(INIT) && !range_err && !locked, "R10 restart wins", int'(reload_val), INIT);
        chk(mst == 1, "R10 boundary consumed, still arming", mst, 1);
        wait_flag(1'b1, 5000);
        chk(locked && reload_val == 7'd10, "R10 new search converges", int'(reload_val), 10);

        // R9 high clamp
        exp_ticks = 8'd1;
        ref_per = 300;
        pulse_start();
        wait_flag(1'b0, 60000);
        chk(range_err && reload_val == 7'(RMAX), "R9 high clamp", int'(reload_val), RMAX);

        // R6 run: a match after restart must not lock early
        exp_ticks = 8'd20;
        ref_per = 201;
        pulse_start();
        repeat (201 * 3) @(negedge clk);
        chk(!locked, "R6 no early lock", int'(locked), 0);
        finish_run();
    end
endmodule